// File: doc/BRIEF.md
# Semi-Parallel Multichannel FIR Filter

This block is a time-multiplexed FIR filter shared by several interleaved channels. The clock runs at `PHASES` times the composite sample rate, which is the channel count multiplied by the per-channel sample rate. Each of the `TAPS_PER_PHASE` multiply-add stages therefore handles `PHASES` coefficients per channel.

The impulse response of `N = PHASES * TAPS_PER_PHASE` taps is split into phases. Tap `i` is assigned to stage `i / PHASES` and to phase `i % PHASES`. When a sample is accepted, the sequencer walks through the phases on consecutive cycles. Each cycle the cascade of stages forms the partial sum of one phase.

The last stage adds three terms: its product, the cascaded partial sum, and its own running total. It restarts the total on phase 0. After `PHASES` cycles it holds one full-precision output sample. No accumulator stage follows the tap chain.

Coefficients start at zero and are written through a simple write port. Samples carry a channel index. Each channel keeps its own sample history.

Top module: `semipar_fir`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and `out_chan_o` and `out_data_o` are 0. Every coefficient and every history entry is cleared to zero.
- R2: Each output of channel c equals the exact sum over taps i = 0..N-1 of h[i]·x_c[n−i]. Here x_c[n] is the sample just accepted for c, and samples older than the first one after reset count as zero.
- R3: A sample is accepted only if at least `PHASES` cycles have passed since the previous accepted sample. An `in_valid_i` arriving sooner is ignored: it writes no history and produces no output.
- R4: Each accepted sample produces exactly one output. `out_valid_o` is high for one cycle, `TAPS_PER_PHASE + PHASES − 1` cycles after the accepting clock edge.
- R5: Two cycles with `out_valid_o` high are always at least `PHASES` cycles apart. With input at the maximum rate, one output appears every `PHASES` cycles.
- R6: `out_chan_o` equals the channel index of the sample that produced the output. A sample whose `in_chan_i` is `CHANNELS` or larger is ignored.
- R7: Interleaved channels do not affect each other's history. The result for one channel depends only on that channel's own samples.
- R8: A write with `coef_we_i` high and `coef_addr_i` = i, where i < N, sets h[i] (delay i samples) from `coef_data_i` at the clock edge. Writes with address N or above are ignored. After reset all coefficients are zero, so every output is zero until coefficients are written.
- R9: No overflow occurs at the extremes of the signed sample and coefficient ranges. The output width is `SAMPLE_W + COEF_W + clog2(N)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_chan_i | input | clog2(CHANNELS) | Channel of the sample |
| in_data_i | input | SAMPLE_W | Signed sample |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | clog2(N) | Tap index to write |
| coef_data_i | input | COEF_W | Signed coefficient |
| out_valid_o | output | 1 | Output sample strobe, one cycle |
| out_chan_o | output | clog2(CHANNELS) | Channel of the output sample |
| out_data_o | output | SAMPLE_W+COEF_W+clog2(N) | Signed full-precision result |

## Verification
Each kind of internal fault shows up at the ports in a predictable way:
- A phase counter that slips moves or drops the next `out_valid_o` pulse. The per-cycle strobe comparison catches this within `TAPS_PER_PHASE + PHASES − 1` cycles of the sample that exposed it.
- A history write to the wrong slot or the wrong channel corrupts up to N later outputs of the affected channel. The interleaved and impulse sequences make such a value differ on the very next output of that channel.
- An accumulator that is not restarted on phase 0 carries the previous total into the next output, so the first mismatching result appears one output later.
- A coefficient decoded at the wrong address shows up as a misplaced term in the impulse response.

// File: rtl/semipar_fir_pkg.sv
package semipar_fir_pkg;

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // ring depth leaves slack for the in-flight reads of the last stage
  function automatic int ring_depth(int taps, int stages);
    return 1 << $clog2(taps + stages);
  endfunction

endpackage

// File: rtl/semipar_fir_seq.sv
module semipar_fir_seq #(
  parameter int CHANNELS = 3,
  parameter int PHASES   = 4,
  parameter int CH_W     = 2,
  parameter int PH_W     = 2,
  parameter int PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [CH_W-1:0]  in_chan_i,
  output logic             accept_o,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic             iss_act_o,
  output logic [PH_W-1:0]  iss_ph_o,
  output logic [CH_W-1:0]  iss_ch_o,
  output logic [PTR_W-1:0] iss_base_o
);

  logic [PTR_W-1:0] wptr_q [CHANNELS];
  logic             act_q;
  logic [PH_W-1:0]  ph_q;
  logic [CH_W-1:0]  ch_q;
  logic [PTR_W-1:0] base_q;
  logic             chan_ok;
  logic             free;
  logic             last_ph;

  assign chan_ok  = {1'b0, in_chan_i} < (CH_W+1)'(CHANNELS);
  assign last_ph  = ph_q == PH_W'(PHASES - 1);
  assign free     = !act_q || last_ph;
  assign accept_o = in_valid_i && chan_ok && free;

  always_comb begin
    wr_slot_o = '0;
    for (int c = 0; c < CHANNELS; c++)
      if (in_chan_i == CH_W'(c)) wr_slot_o = wptr_q[c] + PTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CHANNELS; c++) wptr_q[c] <= '0;
    end else if (accept_o) begin
      for (int c = 0; c < CHANNELS; c++)
        if (in_chan_i == CH_W'(c)) wptr_q[c] <= wr_slot_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      ch_q   <= '0;
      base_q <= '0;
    end else if (accept_o) begin
      act_q  <= 1'b1;
      ph_q   <= '0;
      ch_q   <= in_chan_i;
      base_q <= wr_slot_o;
    end else if (act_q) begin
      if (last_ph) act_q <= 1'b0;
      else         ph_q  <= ph_q + PH_W'(1);
    end
  end

  assign iss_act_o  = act_q;
  assign iss_ph_o   = ph_q;
  assign iss_ch_o   = ch_q;
  assign iss_base_o = base_q;

endmodule

// File: rtl/semipar_fir_hist.sv
module semipar_fir_hist #(
  parameter int CHANNELS = 3,
  parameter int DEPTH    = 16,
  parameter int PTR_W    = 4,
  parameter int CH_W     = 2,
  parameter int SAMPLE_W = 16,
  parameter int PORTS    = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [CH_W-1:0]                 wchan_i,
  input  logic [PTR_W-1:0]                waddr_i,
  input  logic [SAMPLE_W-1:0]             wdata_i,
  input  logic [PORTS-1:0][CH_W-1:0]      rchan_i,
  input  logic [PORTS-1:0][PTR_W-1:0]     raddr_i,
  output logic [PORTS-1:0][SAMPLE_W-1:0]  rdata_o
);

  logic [SAMPLE_W-1:0] mem_q [CHANNELS][DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CHANNELS; c++)
        for (int d = 0; d < DEPTH; d++) mem_q[c][d] <= '0;
    end else if (we_i) begin
      for (int c = 0; c < CHANNELS; c++)
        if (wchan_i == CH_W'(c)) mem_q[c][waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    always_comb begin
      rdata_o[p] = '0;
      for (int c = 0; c < CHANNELS; c++)
        if (rchan_i[p] == CH_W'(c)) rdata_o[p] = mem_q[c][raddr_i[p]];
    end
  end

endmodule

// File: rtl/semipar_fir_tap.sv
module semipar_fir_tap #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 36,
  parameter bit LAST     = 1'b0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       first_i,
  input  logic signed [SAMPLE_W-1:0] samp_i,
  input  logic signed [COEF_W-1:0]   coef_i,
  input  logic signed [ACC_W-1:0]    casc_i,
  output logic signed [ACC_W-1:0]    sum_o
);

  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x;
  logic signed [ACC_W-1:0]  sum_q;

  assign prod   = samp_i * coef_i;
  assign prod_x = ACC_W'(prod);

  if (LAST) begin : g_acc
    // three-input add: product + cascade + own total, restarted on phase 0
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sum_q <= '0;
      else if (en_i) sum_q <= (first_i ? '0 : sum_q) + casc_i + prod_x;
    end
  end else begin : g_mid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q <= '0;
      else         sum_q <= en_i ? casc_i + prod_x : '0;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/semipar_fir.sv
module semipar_fir
  import semipar_fir_pkg::*;
#(
  parameter int CHANNELS       = 3,
  parameter int PHASES         = 4,
  parameter int TAPS_PER_PHASE = 3,
  parameter int SAMPLE_W       = 16,
  parameter int COEF_W         = 16,
  localparam int TAPS  = PHASES * TAPS_PER_PHASE,
  localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(TAPS),
  localparam int CH_W  = idx_w(CHANNELS),
  localparam int TAP_W = idx_w(TAPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [CH_W-1:0]            in_chan_i,
  input  logic signed [SAMPLE_W-1:0] in_data_i,
  input  logic                       coef_we_i,
  input  logic [TAP_W-1:0]           coef_addr_i,
  input  logic signed [COEF_W-1:0]   coef_data_i,
  output logic                       out_valid_o,
  output logic [CH_W-1:0]            out_chan_o,
  output logic signed [ACC_W-1:0]    out_data_o
);

  localparam int PH_W  = idx_w(PHASES);
  localparam int DEPTH = ring_depth(TAPS, TAPS_PER_PHASE);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int TPP   = TAPS_PER_PHASE;

  logic             accept;
  logic [PTR_W-1:0] wr_slot;
  logic             iss_act;
  logic [PH_W-1:0]  iss_ph;
  logic [CH_W-1:0]  iss_ch;
  logic [PTR_W-1:0] iss_base;

  logic [TPP-1:0][CH_W-1:0]     rd_chan;
  logic [TPP-1:0][PTR_W-1:0]    rd_addr;
  logic [TPP-1:0][SAMPLE_W-1:0] rd_data;
  logic [TPP:0][ACC_W-1:0]      casc;

  logic signed [COEF_W-1:0] coef_q [TAPS];

  logic            act_q [TPP];
  logic [PH_W-1:0] ph_q  [TPP];
  logic [CH_W-1:0] ch_q  [TPP];

  semipar_fir_seq #(
    .CHANNELS (CHANNELS),
    .PHASES   (PHASES),
    .CH_W     (CH_W),
    .PH_W     (PH_W),
    .PTR_W    (PTR_W)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_chan_i  (in_chan_i),
    .accept_o   (accept),
    .wr_slot_o  (wr_slot),
    .iss_act_o  (iss_act),
    .iss_ph_o   (iss_ph),
    .iss_ch_o   (iss_ch),
    .iss_base_o (iss_base)
  );

  semipar_fir_hist #(
    .CHANNELS (CHANNELS),
    .DEPTH    (DEPTH),
    .PTR_W    (PTR_W),
    .CH_W     (CH_W),
    .SAMPLE_W (SAMPLE_W),
    .PORTS    (TPP)
  ) i_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (accept),
    .wchan_i (in_chan_i),
    .waddr_i (wr_slot),
    .wdata_i (in_data_i),
    .rchan_i (rd_chan),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) coef_q[i] <= '0;
    end else if (coef_we_i) begin
      for (int i = 0; i < TAPS; i++)
        if ({1'b0, coef_addr_i} == (TAP_W+1)'(i)) coef_q[i] <= coef_data_i;
    end
  end

  // control travels one stage per cycle alongside the cascade
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < TPP; j++) begin
        act_q[j] <= 1'b0;
        ph_q[j]  <= '0;
        ch_q[j]  <= '0;
      end
    end else begin
      act_q[0] <= iss_act;
      ph_q[0]  <= iss_ph;
      ch_q[0]  <= iss_ch;
      for (int j = 1; j < TPP; j++) begin
        act_q[j] <= act_q[j-1];
        ph_q[j]  <= ph_q[j-1];
        ch_q[j]  <= ch_q[j-1];
      end
    end
  end

  if (TPP > 1) begin : g_base
    logic [PTR_W-1:0] base_q [TPP-1];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < TPP-1; j++) base_q[j] <= '0;
      end else begin
        base_q[0] <= iss_base;
        for (int j = 1; j < TPP-1; j++) base_q[j] <= base_q[j-1];
      end
    end
  end

  assign casc[0] = '0;

  for (genvar j = 0; j < TPP; j++) begin : g_stage
    logic                     act_j;
    logic [PH_W-1:0]          ph_j;
    logic [CH_W-1:0]          ch_j;
    logic [PTR_W-1:0]         base_j;
    logic signed [COEF_W-1:0] coef_j;

    if (j == 0) begin : g_head
      assign act_j  = iss_act;
      assign ph_j   = iss_ph;
      assign ch_j   = iss_ch;
      assign base_j = iss_base;
    end else begin : g_body
      assign act_j  = act_q[j-1];
      assign ph_j   = ph_q[j-1];
      assign ch_j   = ch_q[j-1];
      assign base_j = g_base.base_q[j-1];
    end

    // tap index j*PHASES + phase, i.e. that many samples back
    assign rd_chan[j] = ch_j;
    assign rd_addr[j] = base_j - PTR_W'(j * PHASES) - PTR_W'(ph_j);

    always_comb begin
      coef_j = '0;
      for (int p = 0; p < PHASES; p++)
        if (ph_j == PH_W'(p)) coef_j = coef_q[j*PHASES + p];
    end

    semipar_fir_tap #(
      .SAMPLE_W (SAMPLE_W),
      .COEF_W   (COEF_W),
      .ACC_W    (ACC_W),
      .LAST     (j == TPP-1)
    ) i_tap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (act_j),
      .first_i (ph_j == '0),
      .samp_i  ($signed(rd_data[j])),
      .coef_i  (coef_j),
      .casc_i  ($signed(casc[j])),
      .sum_o   (casc[j+1])
    );
  end

  assign out_valid_o = act_q[TPP-1] && (ph_q[TPP-1] == PH_W'(PHASES - 1));
  assign out_chan_o  = ch_q[TPP-1];
  assign out_data_o  = $signed(casc[TPP]);

endmodule

// File: rtl/semipar_fir_chk.sv
module semipar_fir_chk #(
  parameter int CHANNELS = 3,
  parameter int PHASES   = 4,
  parameter int CH_W     = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            accept_i,
  input logic            out_valid_i,
  input logic [CH_W-1:0] out_chan_i
);

  localparam int GAP_W = $clog2(PHASES + 1) + 1;

  logic [GAP_W-1:0] acc_gap_q;
  logic [GAP_W-1:0] out_gap_q;
  logic [7:0]       pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_gap_q <= GAP_W'(PHASES);
      out_gap_q <= GAP_W'(PHASES);
      pending_q <= '0;
    end else begin
      if (accept_i)                          acc_gap_q <= GAP_W'(1);
      else if (acc_gap_q < GAP_W'(PHASES))   acc_gap_q <= acc_gap_q + GAP_W'(1);
      if (out_valid_i)                       out_gap_q <= GAP_W'(1);
      else if (out_gap_q < GAP_W'(PHASES))   out_gap_q <= out_gap_q + GAP_W'(1);
      pending_q <= pending_q + 8'(accept_i) - 8'(out_valid_i);
    end
  end

  p_accept_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> acc_gap_q >= GAP_W'(PHASES));

  p_out_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> pending_q != 8'd0);

  p_out_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> out_gap_q >= GAP_W'(PHASES));

  p_chan_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> ({1'b0, out_chan_i} < (CH_W+1)'(CHANNELS)));

endmodule

bind semipar_fir semipar_fir_chk #(
  .CHANNELS (CHANNELS),
  .PHASES   (PHASES),
  .CH_W     (CH_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept_i    (accept),
  .out_valid_i (out_valid_o),
  .out_chan_i  (out_chan_o)
);

// File: tb/test_semipar_fir.sv
module test_semipar_fir;

  localparam int C  = 3;
  localparam int K  = 4;
  localparam int M  = 3;
  localparam int N  = K * M;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int AW = SW + CW + $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 in_valid_i = 1'b0;
  logic [1:0]           in_chan_i = '0;
  logic signed [SW-1:0] in_data_i = '0;
  logic                 coef_we_i = 1'b0;
  logic [3:0]           coef_addr_i = '0;
  logic signed [CW-1:0] coef_data_i = '0;
  logic                 out_valid_o;
  logic [1:0]           out_chan_o;
  logic signed [AW-1:0] out_data_o;

  always #5 clk = ~clk;

  semipar_fir i_semipar_fir (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_chan_i   (in_chan_i),
    .in_data_i   (in_data_i),
    .coef_we_i   (coef_we_i),
    .coef_addr_i (coef_addr_i),
    .coef_data_i (coef_data_i),
    .out_valid_o (out_valid_o),
    .out_chan_o  (out_chan_o),
    .out_data_o  (out_data_o)
  );

  typedef struct {
    longint due;
    int     ch;
    longint val;
  } exp_t;

  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  longint last_acc = -100;
  int     coef_m [N];
  int     hist [C][$];
  exp_t   eq [$];
  string  cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int rnd16();
    logic [15:0] r;
    r = 16'($urandom);
    return int'($signed(r));
  endfunction

  // reference: admission rule, per-channel history, direct convolution
  task automatic model_sample(int ch, int d, longint e);
    longint y;
    exp_t   x;
    if (ch >= C || e - last_acc < K) return;
    last_acc = e;
    hist[ch].push_front(d);
    if (hist[ch].size() > N) void'(hist[ch].pop_back());
    y = 0;
    for (int i = 0; i < hist[ch].size(); i++) y += longint'(coef_m[i]) * longint'(hist[ch][i]);
    x.due = e + M + K - 1;
    x.ch  = ch;
    x.val = y;
    eq.push_back(x);
  endtask

  task automatic step(bit v, int ch, int d, bit cw = 1'b0, int ca = 0, int cd = 0);
    @(negedge clk);
    in_valid_i  = v;
    in_chan_i   = 2'(ch);
    in_data_i   = 16'(d);
    coef_we_i   = cw;
    coef_addr_i = 4'(ca);
    coef_data_i = 16'(cd);
    if (cw && ca < N) coef_m[ca] = int'($signed(16'(cd)));
    if (v) model_sample(ch, d, cyc + 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  task automatic load_all(int val);
    for (int i = 0; i < N; i++) step(1'b0, 0, 0, 1'b1, i, val);
    step(1'b0, 0, 0);
  endtask

  // compared on every cycle against the reference schedule
  always @(negedge clk) begin
    if (rst_ni) begin
      bit e;
      e = (eq.size() > 0) && (eq[0].due == cyc);
      chk(out_valid_o == e, {cur_req, "/R4"}, longint'(out_valid_o), longint'(e));
      if (e) begin
        if (out_valid_o) begin
          chk(int'(out_chan_o) == eq[0].ch, "R6", longint'(out_chan_o), longint'(eq[0].ch));
          chk(longint'(out_data_o) == eq[0].val, cur_req, longint'(out_data_o), eq[0].val);
        end
        void'(eq.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) coef_m[i] = 0;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid_o == 1'b0, "R1", longint'(out_valid_o), 0);
    chk(out_chan_o == 2'd0, "R1", longint'(out_chan_o), 0);
    chk(out_data_o == '0, "R1", longint'(out_data_o), 0);
    rst_ni = 1'b1;

    // R8 zero coefficients after reset
    cur_req = "R8";
    step(1'b1, 0, 1234);
    idle(K + M + 2);
    for (int i = 0; i < N; i++) step(1'b0, 0, 0, 1'b1, i, (i % 2 == 1) ? -37 * (i + 1) : 37 * (i + 1));
    for (int a = N; a < 16; a++) step(1'b0, 0, 0, 1'b1, a, 5000);
    idle(2);

    // R2 impulse response on channel 1
    cur_req = "R2";
    step(1'b1, 1, 1);
    idle(K - 1);
    for (int n = 0; n < N + 2; n++) begin
      step(1'b1, 1, 0);
      idle(K - 1);
    end
    idle(M + K);

    // R7 interleaved channels at full rate
    cur_req = "R7";
    for (int n = 0; n < 60; n++) begin
      step(1'b1, n % C, rnd16());
      idle(K - 1);
    end

    // R3 strobe every cycle, most must be dropped
    cur_req = "R3";
    for (int n = 0; n < 24; n++) step(1'b1, 0, rnd16());
    idle(M + K);

    // R6 out-of-range channel index ignored
    cur_req = "R6";
    for (int n = 0; n < 20; n++) begin
      step(1'b1, n % 4, rnd16());
      idle(K - 1);
    end

    // R5 irregular gaps
    cur_req = "R5";
    for (int n = 0; n < 30; n++) begin
      step(1'b1, int'($urandom % C), rnd16());
      idle(K - 1 + int'($urandom % 3));
    end
    idle(M + K + 2);

    // R9 extreme operands
    cur_req = "R9";
    load_all(-32768);
    for (int n = 0; n < N + 2; n++) begin
      step(1'b1, 2, -32768);
      idle(K - 1);
    end
    idle(M + K + 1);
    load_all(32767);
    for (int n = 0; n < N; n++) begin
      step(1'b1, 2, -32768);
      idle(K - 1);
    end
    idle(M + K + 4);
    chk(eq.size() == 0, "R4", longint'(eq.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule